// File: doc/BRIEF.md
# Bidirectional 8-bit I/O Port with Per-Pin Pull-Up Control

This block is the register and pin logic for one 8-bit general-purpose I/O port on a microcontroller peripheral bus. Software sets each pin's direction, writes output levels into a data latch, and enables a weak pull-up on each pin separately. The pull-up control passes to the pad only for pins set as inputs, and only while the chip runs in its single-chip operating mode. A read-only pin-state register combines the two views of the port. Pins set as outputs return the level held in the latch. Pins set as inputs return the pad level after it has passed through a two-stage synchronizer.

The block takes two kinds of initialisation. Power-on reset and hardware standby are asynchronous and clear every register, so all pins come up as inputs with pull-ups off. Manual reset and software standby keep the whole configuration as it was. While either of these is high, the block accepts no bus write. The operating mode comes in as a plain input. The pad drivers and the analog pull-up devices lie outside the block.

Top module: `gpio_pull_port`

## Requirements
- R1: Address 0 holds the direction register. It is written with busWrite and read back unchanged. padOe equals it bit for bit, where 1 means the pin is an output.
- R2: Address 1 holds the output data latch. It is written with busWrite and read back unchanged. padOut equals it bit for bit.
- R3: A read of address 2 returns, for each bit whose direction bit is 1, the latch bit. For each bit whose direction bit is 0, it returns the padIn level captured at the second-to-last rising clock edge, after two synchronizer stages.
- R4: A write to address 2 has no effect. The direction, latch and pull-up registers all keep their values.
- R5: Address 3 holds the pull-up control register, with one bit per pin. It is written with busWrite and read back unchanged.
- R6: pullEn[i] is 1 exactly when direction bit i is 0, pull-up bit i is 1, and opMode equals 7. In every other case it is 0.
- R7: While porReset or hwStandby is high, the direction, latch and pull-up registers and both synchronizer stages are cleared to 0x00 at once, without waiting for a clock edge.
- R8: While manualReset or swStandby is high, bus writes are ignored and every register keeps its value.
- R9: After a clearing reset all pins are inputs, so a read of address 2 returns the synchronized pad levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and port clock |
| porReset | input | 1 | Power-on reset, asynchronous, active high, clears all registers |
| hwStandby | input | 1 | Hardware standby, asynchronous, active high, clears all registers |
| manualReset | input | 1 | Manual reset, keeps registers and blocks writes |
| swStandby | input | 1 | Software standby, keeps registers and blocks writes |
| opMode | input | 3 | Chip operating mode; 7 is single-chip mode |
| busAddr | input | 2 | Register select: 0 direction, 1 latch, 2 pin state, 3 pull-up |
| busWrite | input | 1 | Write strobe, sampled on the rising clock edge |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Combinational read data for busAddr |
| padIn | input | 8 | Pad input levels |
| padOut | output | 8 | Pad output data |
| padOe | output | 8 | Per-pin output enable |
| pullEn | output | 8 | Per-pin pull-up enable |

## Verification
Pin-state reads are applied with mixed direction masks such as 0xF0 and 0x0F, while padIn carries complementary patterns like 0x3C and 0xC3. This separates a latch-sourced bit from a pin-sourced bit and catches a mask that is swapped or inverted. Changing padIn from one cycle to the next shows whether the synchronizer adds exactly two cycles of delay. The pull-up register is exercised with opMode at 7 and at other values, and with direction masks that overlap it. Writes sent during manual reset, during software standby and to the pin-state address confirm that nothing is stored. A clearing reset applied in the middle of a run, followed by a long randomized stretch, covers interactions that the directed patterns miss.

// File: rtl/gpio_pull_port_pkg.sv
package gpio_pull_port_pkg;

  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_LAT  = 2'd1,
    SEL_PIN  = 2'd2,
    SEL_PULL = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrDir;
    logic    wrLat;
    logic    wrPull;
    regSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_pull_ctrl.sv
module gpio_pull_ctrl
  import gpio_pull_port_pkg::*;
(
  input  logic        manualReset,
  input  logic        swStandby,
  input  logic [1:0]  busAddr,
  input  logic        busWrite,
  output ctrlStrobe_t strobe
);

  logic    holdRegs;
  logic    wrOk;
  regSel_e sel;

  always_comb begin
    holdRegs = manualReset | swStandby;
    wrOk     = busWrite & ~holdRegs;
    sel      = regSel_e'(busAddr);
    strobe.rdSel  = sel;
    strobe.wrDir  = wrOk && (sel == SEL_DIR);
    strobe.wrLat  = wrOk && (sel == SEL_LAT);
    strobe.wrPull = wrOk && (sel == SEL_PULL);
  end

endmodule

// File: rtl/gpio_pull_dp.sv
module gpio_pull_dp
  import gpio_pull_port_pkg::*;
#(
  parameter int WIDTH            = 8,
  parameter int MODE_W           = 3,
  parameter int SINGLE_CHIP_MODE = 7
) (
  input  logic              clk,
  input  logic              asyncClr,
  input  ctrlStrobe_t       strobe,
  input  logic [WIDTH-1:0]  busWdata,
  input  logic [WIDTH-1:0]  padIn,
  input  logic [MODE_W-1:0] opMode,
  output logic [WIDTH-1:0]  busRdata,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  pullEn
);

  localparam logic [MODE_W-1:0] PULL_MODE = MODE_W'(SINGLE_CHIP_MODE);

  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] latReg;
  logic [WIDTH-1:0] pullReg;
  logic [WIDTH-1:0] syncA;
  logic [WIDTH-1:0] syncB;
  logic [WIDTH-1:0] pinView;
  logic             pullModeOk;

  always_ff @(posedge clk or posedge asyncClr) begin
    if (asyncClr) begin
      dirReg  <= '0;
      latReg  <= '0;
      pullReg <= '0;
    end else begin
      if (strobe.wrDir)  dirReg  <= busWdata;
      if (strobe.wrLat)  latReg  <= busWdata;
      if (strobe.wrPull) pullReg <= busWdata;
    end
  end

  always_ff @(posedge clk or posedge asyncClr) begin
    if (asyncClr) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  assign pullModeOk = (opMode == PULL_MODE);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign pinView[b] = dirReg[b] ? latReg[b] : syncB[b];
    assign pullEn[b]  = pullModeOk & ~dirReg[b] & pullReg[b];
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_DIR:  busRdata = dirReg;
      SEL_LAT:  busRdata = latReg;
      SEL_PIN:  busRdata = pinView;
      SEL_PULL: busRdata = pullReg;
      default:  busRdata = '0;
    endcase
  end

  assign padOut = latReg;
  assign padOe  = dirReg;

endmodule

// File: rtl/gpio_pull_port.sv
module gpio_pull_port
  import gpio_pull_port_pkg::*;
#(
  parameter int WIDTH            = 8,
  parameter int MODE_W           = 3,
  parameter int SINGLE_CHIP_MODE = 7
) (
  input  logic              clk,
  input  logic              porReset,
  input  logic              hwStandby,
  input  logic              manualReset,
  input  logic              swStandby,
  input  logic [MODE_W-1:0] opMode,
  input  logic [1:0]        busAddr,
  input  logic              busWrite,
  input  logic [WIDTH-1:0]  busWdata,
  output logic [WIDTH-1:0]  busRdata,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  pullEn
);

  ctrlStrobe_t strobe;
  logic        asyncClr;

  assign asyncClr = porReset | hwStandby;

  gpio_pull_ctrl u_ctrl (
    .manualReset (manualReset),
    .swStandby   (swStandby),
    .busAddr     (busAddr),
    .busWrite    (busWrite),
    .strobe      (strobe)
  );

  gpio_pull_dp #(
    .WIDTH            (WIDTH),
    .MODE_W           (MODE_W),
    .SINGLE_CHIP_MODE (SINGLE_CHIP_MODE)
  ) u_dp (
    .clk      (clk),
    .asyncClr (asyncClr),
    .strobe   (strobe),
    .busWdata (busWdata),
    .padIn    (padIn),
    .opMode   (opMode),
    .busRdata (busRdata),
    .padOut   (padOut),
    .padOe    (padOe),
    .pullEn   (pullEn)
  );

endmodule

// File: rtl/gpio_pull_port_chk.sv
module gpio_pull_port_chk #(
  parameter int WIDTH            = 8,
  parameter int MODE_W           = 3,
  parameter int SINGLE_CHIP_MODE = 7
) (
  input logic              clk,
  input logic              porReset,
  input logic              hwStandby,
  input logic              manualReset,
  input logic              swStandby,
  input logic [MODE_W-1:0] opMode,
  input logic [1:0]        busAddr,
  input logic              busWrite,
  input logic [WIDTH-1:0]  busRdata,
  input logic [WIDTH-1:0]  padOut,
  input logic [WIDTH-1:0]  padOe,
  input logic [WIDTH-1:0]  pullEn
);

  logic clr;
  logic hold;
  assign clr  = porReset | hwStandby;
  assign hold = manualReset | swStandby;

  // R6
  pull_vs_oe_chk: assert property (@(posedge clk) disable iff (clr)
    (pullEn & padOe) == '0);

  // R6
  pull_mode_chk: assert property (@(posedge clk) disable iff (clr)
    (opMode != MODE_W'(SINGLE_CHIP_MODE)) |-> (pullEn == '0));

  // R3
  pin_out_bits_chk: assert property (@(posedge clk) disable iff (clr)
    (busAddr == 2'd2) |-> ((busRdata & padOe) == (padOut & padOe)));

  // R8
  hold_regs_chk: assert property (@(posedge clk) disable iff (clr)
    hold |=> ($stable(padOut) && $stable(padOe)));

  // R4
  pin_write_ignored_chk: assert property (@(posedge clk) disable iff (clr)
    (busWrite && busAddr == 2'd2) |=> ($stable(padOut) && $stable(padOe)));

  // R1
  dir_only_on_write_chk: assert property (@(posedge clk) disable iff (clr)
    !(busWrite && !hold && busAddr == 2'd0) |=> $stable(padOe));

  // R7
  clr_state_chk: assert property (@(posedge clk)
    clr |-> (padOe == '0 && padOut == '0 && pullEn == '0));

endmodule

bind gpio_pull_port gpio_pull_port_chk #(
  .WIDTH            (WIDTH),
  .MODE_W           (MODE_W),
  .SINGLE_CHIP_MODE (SINGLE_CHIP_MODE)
) u_chk (
  .clk         (clk),
  .porReset    (porReset),
  .hwStandby   (hwStandby),
  .manualReset (manualReset),
  .swStandby   (swStandby),
  .opMode      (opMode),
  .busAddr     (busAddr),
  .busWrite    (busWrite),
  .busRdata    (busRdata),
  .padOut      (padOut),
  .padOe       (padOe),
  .pullEn      (pullEn)
);

// File: tb/tb_gpio_pull_port.sv
`timescale 1ns/1ps
module tb_gpio_pull_port;

  logic       clk = 1'b0;
  logic       porReset = 1'b1;
  logic       hwStandby = 1'b0;
  logic       manualReset = 1'b0;
  logic       swStandby = 1'b0;
  logic [2:0] opMode = 3'd7;
  logic [1:0] busAddr = 2'd0;
  logic       busWrite = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic [7:0] padIn = 8'h00;
  logic [7:0] padOut;
  logic [7:0] padOe;
  logic [7:0] pullEn;

  always #2 clk = ~clk;

  gpio_pull_port dut (
    .clk         (clk),
    .porReset    (porReset),
    .hwStandby   (hwStandby),
    .manualReset (manualReset),
    .swStandby   (swStandby),
    .opMode      (opMode),
    .busAddr     (busAddr),
    .busWrite    (busWrite),
    .busWdata    (busWdata),
    .busRdata    (busRdata),
    .padIn       (padIn),
    .padOut      (padOut),
    .padOe       (padOe),
    .pullEn      (pullEn)
  );

  // behavioural reference state
  int unsigned mDir, mLat, mPull;
  int unsigned padHist[$];
  int vectors = 0;
  int misses  = 0;
  string phase = "R1";
  bit finished = 0;

  function automatic int unsigned syncedPad();
    return padHist[0];
  endfunction

  task automatic modelClear();
    mDir = 0; mLat = 0; mPull = 0;
    padHist = '{0, 0};
  endtask

  task automatic compareAll();
    int unsigned eR, eP, sp;
    string tag;
    sp = syncedPad();
    case (busAddr)
      2'd0: begin eR = mDir;  tag = "R1"; end
      2'd1: begin eR = mLat;  tag = "R2"; end
      2'd2: begin eR = (mDir & mLat) | (~mDir & sp & 32'hFF); tag = "R3"; end
      default: begin eR = mPull; tag = "R5"; end
    endcase
    eR = eR & 32'hFF;
    eP = (opMode == 3'd7) ? ((~mDir) & mPull & 32'hFF) : 0;
    vectors++;
    if (busRdata !== 8'(eR)) begin
      misses++;
      $display("FAIL %s/%s busRdata addr=%0d actual=%h expected=%h", tag, phase, busAddr, busRdata, eR[7:0]);
    end
    if (padOe !== 8'(mDir)) begin
      misses++;
      $display("FAIL R1/%s padOe actual=%h expected=%h", phase, padOe, mDir[7:0]);
    end
    if (padOut !== 8'(mLat)) begin
      misses++;
      $display("FAIL R2/%s padOut actual=%h expected=%h", phase, padOut, mLat[7:0]);
    end
    if (pullEn !== 8'(eP)) begin
      misses++;
      $display("FAIL R6/%s pullEn actual=%h expected=%h", phase, pullEn, eP[7:0]);
    end
  endtask

  // one cycle: drive at falling edge, compare, then advance the model at the rising edge
  task automatic step(input bit wr, input logic [1:0] a, input logic [7:0] d,
                      input logic [7:0] pin, input logic [2:0] mode,
                      input bit mr, input bit ss, input bit por, input bit hs);
    @(negedge clk);
    busWrite = wr; busAddr = a; busWdata = d; padIn = pin; opMode = mode;
    manualReset = mr; swStandby = ss; porReset = por; hwStandby = hs;
    #0.5;
    if (por || hs) modelClear();
    compareAll();
    @(posedge clk);
    if (por || hs) modelClear();
    else begin
      if (wr && !mr && !ss) begin
        case (a)
          2'd0: mDir  = d;
          2'd1: mLat  = d;
          2'd3: mPull = d;
          default: ;
        endcase
      end
      void'(padHist.pop_front());
      padHist.push_back(pin);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [7:0] pin);
    step(1, a, d, pin, 3'd7, 0, 0, 0, 0);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] pin, input logic [2:0] mode);
    step(0, a, 8'h00, pin, mode, 0, 0, 0, 0);
  endtask

  initial begin
    modelClear();
    // R7: clearing reset state
    phase = "R7";
    step(0, 2'd0, 8'h00, 8'h00, 3'd7, 0, 0, 1, 0);
    step(0, 2'd2, 8'h00, 8'h00, 3'd7, 0, 0, 1, 0);

    // R9: all inputs after reset, pad levels come through with two-cycle delay
    phase = "R9";
    rd(2'd2, 8'h5A, 3'd7);
    rd(2'd2, 8'hC3, 3'd7);
    rd(2'd2, 8'h3C, 3'd7);
    rd(2'd2, 8'hFF, 3'd7);
    rd(2'd2, 8'h00, 3'd7);
    rd(2'd2, 8'h00, 3'd7);

    // R1 R2: direction and latch write/readback
    phase = "R1";
    wr(2'd0, 8'hF0, 8'h3C);
    rd(2'd0, 8'h3C, 3'd7);
    phase = "R2";
    wr(2'd1, 8'hA5, 8'h3C);
    rd(2'd1, 8'hC3, 3'd7);

    // R3: mixed pin-state reads
    phase = "R3";
    rd(2'd2, 8'hC3, 3'd7);
    rd(2'd2, 8'h3C, 3'd7);
    rd(2'd2, 8'h3C, 3'd7);
    wr(2'd0, 8'h0F, 8'hC3);
    rd(2'd2, 8'hC3, 3'd7);
    rd(2'd2, 8'hC3, 3'd7);

    // R4: writes to pin-state address do nothing
    phase = "R4";
    wr(2'd2, 8'hFF, 8'h00);
    wr(2'd2, 8'h00, 8'h00);
    rd(2'd0, 8'h00, 3'd7);
    rd(2'd1, 8'h00, 3'd7);
    rd(2'd3, 8'h00, 3'd7);

    // R5 R6: pull-up register and enable gating
    phase = "R5";
    wr(2'd3, 8'hFF, 8'h00);
    rd(2'd3, 8'h00, 3'd7);
    phase = "R6";
    rd(2'd3, 8'h00, 3'd5);
    rd(2'd3, 8'h00, 3'd6);
    wr(2'd0, 8'hF0, 8'h00);
    rd(2'd0, 8'h00, 3'd7);
    rd(2'd0, 8'h00, 3'd3);
    wr(2'd3, 8'h5A, 8'h00);
    rd(2'd0, 8'h00, 3'd7);

    // R8: hold inputs block writes
    phase = "R8";
    step(1, 2'd0, 8'h11, 8'h00, 3'd7, 1, 0, 0, 0);
    step(1, 2'd1, 8'h22, 8'h00, 3'd7, 1, 0, 0, 0);
    step(1, 2'd3, 8'h33, 8'h00, 3'd7, 0, 1, 0, 0);
    step(1, 2'd0, 8'h44, 8'h00, 3'd7, 1, 1, 0, 0);
    rd(2'd0, 8'h00, 3'd7);
    rd(2'd1, 8'h00, 3'd7);
    rd(2'd3, 8'h00, 3'd7);

    // R7: hardware standby clears mid-run
    phase = "R7";
    step(0, 2'd3, 8'h00, 8'hAA, 3'd7, 0, 0, 0, 1);
    rd(2'd0, 8'hAA, 3'd7);
    phase = "R9";
    rd(2'd2, 8'h55, 3'd7);
    rd(2'd2, 8'h55, 3'd7);
    rd(2'd2, 8'h55, 3'd7);

    // randomized stretch
    phase = "RND";
    for (int i = 0; i < 400; i++) begin
      automatic int unsigned r = $urandom;
      step(r[0], r[2:1], 8'($urandom), 8'($urandom), (r[5:3] < 3'd4) ? 3'd7 : r[5:3],
           (r[11:8] == 4'd0), (r[11:8] == 4'd1), (r[15:12] == 4'd0), 0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      misses++;
      $display("FAIL watchdog expired in phase %s actual=hung expected=done", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule